// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

This block is an asynchronous serial transceiver with a sixteen-entry queue on each side. Software pushes bytes into a transmit queue through a small register bus. The transmitter drains the queue and sends each byte on `txd` as a frame: a low start bit, eight data bits with the least significant bit first, an optional parity bit and one high stop bit. The receiver oversamples `rxd` sixteen times per bit and samples each bit at its midpoint. Each received byte goes into a receive queue together with two error tags, one for parity and one for framing.

The transmitter and receiver share one bit-rate generator. The generator counts the peripheral clock through a prescaler of 1, 4, 16 or 64, then divides by `N+1` to make a sixteen-per-bit tick.

The host can read how many bytes each queue holds and how many stored receive bytes carry an error tag. The block flags line breaks, receive time-outs, receive overruns and transmit overflows. It drives four separate interrupt lines.

While `clk_stop` is high, every register holds its value, so the port can be parked to save power.

The transmitter state machine has five states:
- TX_IDLE moves to TX_START on a tick when the queue is not empty, and pops a byte.
- TX_START moves to TX_DATA after 16 ticks.
- TX_DATA moves to TX_PARITY or TX_STOP after eight bits.
- TX_PARITY moves to TX_STOP.
- TX_STOP moves back to TX_IDLE.

The receiver state machine has six states:
- RX_IDLE moves to RX_START when it sees a low line on a tick.
- RX_START returns to RX_IDLE if the line is high at the start-bit midpoint; otherwise it moves to RX_DATA.
- RX_DATA moves to RX_PARITY or RX_STOP after eight bits.
- RX_PARITY moves to RX_STOP.
- RX_STOP moves to RX_IDLE at the stop midpoint when the line is high. When the line is low, it moves to RX_LINEWAIT.
- RX_LINEWAIT holds until the line goes high again.

Top module: `fifo_uart_port`

## Requirements
- R1: The `txd` line idles high. A frame is a 0 start bit, 8 data bits with the LSB first, a parity bit only when CTRL[2]=1, and a 1 stop bit. A byte written to address 0 and looped back is read unchanged from address 1, and that read pops it.
- R2: One bit lasts 16·(N+1)·D clocks. N is the register at address 3. D is 1, 4, 16 or 64 for CTRL[1:0] = 0, 1, 2 or 3. CTRL is address 2.
- R3: With CTRL[2]=1, the parity bit is the XOR of the data (even) when CTRL[3]=0, and its inverse (odd) when CTRL[3]=1. A received byte whose parity bit mismatches is stored with its parity tag set. The head byte's tag reads as STATUS[5]; STATUS is address 4.
- R4: Address 5 reads the transmit queue fill, address 6 the receive queue fill, and address 7 the number of stored receive bytes with any error tag. Popping a tagged byte decrements the error count.
- R5: A write to address 0 while the transmit queue holds 16 bytes is dropped and sets the sticky STATUS[3].
- R6: A byte received while the receive queue holds 16 bytes is dropped and sets the sticky STATUS[2]. Queued bytes keep their order.
- R7: A frame whose stop bit is 0 and which is not a break is stored with its framing tag set. The head byte's tag reads as STATUS[4].
- R8: A line held low through the whole frame, stop bit included, stores nothing and sets STATUS[1] once. The flag does not set again until the line has returned high.
- R9: STATUS[0] (time-out) sets after 15 bit periods in which the receiver saw no start bit while the receive fill was between 1 and RX_TRIG-1.
- R10: The interrupt lines work as follows:
  - `irq_tx_empty` is high when the transmit fill is 0.
  - `irq_rx_full` is high when the receive fill is at least RX_TRIG (default 8) or STATUS[0] is set.
  - `irq_rx_err` is high when the error count is non-zero or STATUS[2] is set.
  - `irq_break` follows STATUS[1].
- R11: While `clk_stop` is 1, bus writes, pops and line activity change no state, and `txd` holds its level.
- R12: After reset, all fills and flags are 0, `txd` is 1, `irq_tx_empty` is 1 and the other interrupt lines are 0. Writing 1s to STATUS bits [3:0] clears those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_stop | input | 1 | Freezes all state while high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at address 1) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx_empty | output | 1 | Transmit queue empty request |
| irq_break | output | 1 | Break detected request |
| irq_rx_full | output | 1 | Receive threshold or time-out request |
| irq_rx_err | output | 1 | Receive error or overrun request |

## Verification
If a fill counter drifts, the error shows at the count registers right away. It reaches an interrupt line only when a threshold is crossed, and by then the same data is already compared on the read port. A receiver that samples off-centre or lags by a tick loses a byte or tags it falsely within a single frame of loopback, which shows up as a wrong byte or a non-zero error count. An error-tag count that does not track the queue shows as a stuck `irq_rx_err` after the tagged byte is popped. A time-out counter that is too fast or too slow shows only after about fifteen bit periods of silence, so the bench samples either side of that window.

// File: rtl/fifo_uart_pkg.sv
package fifo_uart_pkg;

    localparam int OVS      = 16;
    localparam int DATA_W   = 8;
    localparam int SUB_W    = $clog2(OVS);

    localparam logic [2:0] ADDR_TXDATA = 3'd0;
    localparam logic [2:0] ADDR_RXDATA = 3'd1;
    localparam logic [2:0] ADDR_CTRL   = 3'd2;
    localparam logic [2:0] ADDR_BAUD   = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;
    localparam logic [2:0] ADDR_TXCNT  = 3'd5;
    localparam logic [2:0] ADDR_RXCNT  = 3'd6;
    localparam logic [2:0] ADDR_ERRCNT = 3'd7;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_LINEWAIT
    } rx_state_t;

    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic [6:0] prescale_div(input logic [1:0] code);
        case (code)
            2'd0:    return 7'd1;
            2'd1:    return 7'd4;
            2'd2:    return 7'd16;
            default: return 7'd64;
        endcase
    endfunction

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/fifo_uart_fifo.sv
module fifo_uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = en && push && !full;
    assign do_pop  = en && pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fifo_uart_baud.sv
module fifo_uart_baud
    import fifo_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] presc_sel,
    input  logic [7:0] baud_n,
    output logic       tick16
);
    logic [6:0] pcnt;
    logic [7:0] bcnt;
    logic       pre_tick;

    assign pre_tick = (pcnt >= (prescale_div(presc_sel) - 7'd1));
    assign tick16   = pre_tick && (bcnt >= baud_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            bcnt <= '0;
        end else if (en) begin
            pcnt <= pre_tick ? '0 : pcnt + 7'd1;
            if (pre_tick) begin
                bcnt <= (bcnt >= baud_n) ? '0 : bcnt + 8'd1;
            end
        end
    end
endmodule

// File: rtl/fifo_uart_tx.sv
module fifo_uart_tx
    import fifo_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick16,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              txd
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    tx_state_t         state, nxt;
    logic [SUB_W-1:0]  sub;
    logic [BIT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              bit_end;

    assign bit_end = tick16 && (sub == SUB_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (tick16 && !fifo_empty) nxt = TX_START;
            TX_START:  if (bit_end) nxt = TX_DATA;
            TX_DATA:   if (bit_end && bitcnt == BIT_LAST) nxt = par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) nxt = TX_STOP;
            TX_STOP:   if (bit_end) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            sub     <= '0;
            bitcnt  <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (en) begin
            state <= nxt;
            if (state == TX_IDLE) begin
                sub <= '0;
            end else if (tick16) begin
                sub <= sub + 1'b1;
            end
            if (state != TX_DATA) begin
                bitcnt <= '0;
            end else if (bit_end) begin
                bitcnt <= bitcnt + 1'b1;
            end
            if (fifo_pop) begin
                shreg   <= fifo_data;
                par_bit <= parity_of(fifo_data, par_odd);
            end else if (state == TX_DATA && bit_end) begin
                shreg <= shreg >> 1;
            end
        end
    end

    always_comb begin
        fifo_pop = 1'b0;
        txd      = 1'b1;
        unique case (state)
            TX_IDLE:   fifo_pop = tick16 && !fifo_empty;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_bit;
            TX_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/fifo_uart_rx.sv
module fifo_uart_rx
    import fifo_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick16,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    output logic              byte_vld,
    output rx_entry_t         byte_out,
    output logic              brk_pulse,
    output logic              rx_idle
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    rx_state_t         state, nxt;
    logic              rxd_m, rxd_s;
    logic [SUB_W-1:0]  sub;
    logic [BIT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              par_seen;
    logic              mid, bend, stop_mid, is_break;

    assign mid  = tick16 && (sub == SUB_MID);
    assign bend = tick16 && (sub == SUB_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:     if (tick16 && !rxd_s) nxt = RX_START;
            RX_START:    if (mid && rxd_s) nxt = RX_IDLE;
                         else if (bend) nxt = RX_DATA;
            RX_DATA:     if (bend && bitcnt == BIT_LAST) nxt = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY:   if (bend) nxt = RX_STOP;
            RX_STOP:     if (mid) nxt = rxd_s ? RX_IDLE : RX_LINEWAIT;
            RX_LINEWAIT: if (rxd_s) nxt = RX_IDLE;
            default:     nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_m    <= 1'b1;
            rxd_s    <= 1'b1;
            state    <= RX_IDLE;
            sub      <= '0;
            bitcnt   <= '0;
            shreg    <= '0;
            par_seen <= 1'b0;
        end else if (en) begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
            state <= nxt;
            if (state == RX_IDLE || state == RX_LINEWAIT) begin
                sub      <= '0;
                par_seen <= 1'b0;
            end else if (tick16) begin
                sub <= sub + 1'b1;
            end
            if (state != RX_DATA) begin
                bitcnt <= '0;
            end else if (bend) begin
                bitcnt <= bitcnt + 1'b1;
            end
            if (state == RX_DATA && mid) begin
                shreg <= {rxd_s, shreg[DATA_W-1:1]};
            end
            if (state == RX_PARITY && mid) begin
                par_seen <= rxd_s;
            end
        end
    end

    always_comb begin
        stop_mid      = (state == RX_STOP) && mid;
        is_break      = stop_mid && !rxd_s && (shreg == '0) && !par_seen;
        brk_pulse     = is_break;
        byte_vld      = stop_mid && !is_break;
        byte_out.data = shreg;
        byte_out.ferr = !rxd_s;
        byte_out.perr = par_en && (par_seen != parity_of(shreg, par_odd));
        rx_idle       = (state == RX_IDLE);
    end
endmodule

// File: rtl/fifo_uart_port.sv
module fifo_uart_port
    import fifo_uart_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int RX_TRIG  = 8,
    parameter int TMO_BITS = 15,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_stop,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq_tx_empty,
    output logic       irq_break,
    output logic       irq_rx_full,
    output logic       irq_rx_err
);
    localparam int TMO_TICKS = TMO_BITS * OVS;
    localparam int TMO_W     = $clog2(TMO_TICKS + 1);
    localparam int RXE_W     = $bits(rx_entry_t);

    logic             en;
    logic [1:0]       presc_sel;
    logic             par_en, par_odd;
    logic [7:0]       baud_n;
    logic             tick16;

    logic             tx_push, tx_pop, tx_full, tx_empty;
    logic [7:0]       tx_head;
    logic [CNT_W-1:0] tx_cnt;

    logic             rx_byte_vld, rx_brk, rx_idle;
    rx_entry_t        rx_byte, rx_head;
    logic [RXE_W-1:0] rx_head_raw;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [CNT_W-1:0] rx_cnt, err_cnt;

    logic             flag_tmo, flag_brk, flag_ovr, flag_txovf;
    logic [TMO_W-1:0] tmo_cnt;
    logic             tmo_arm, tmo_hit;
    logic             wr_tx, wr_status, push_tag, pop_tag;

    assign en        = !clk_stop;
    assign wr_tx     = en && bus_wr && (bus_addr == ADDR_TXDATA);
    assign wr_status = en && bus_wr && (bus_addr == ADDR_STATUS);
    assign tx_push   = wr_tx;
    assign rx_push   = en && rx_byte_vld;
    assign rx_pop    = en && bus_rd && (bus_addr == ADDR_RXDATA);
    assign rx_head   = rx_entry_t'(rx_head_raw);
    assign push_tag  = rx_push && !rx_full && (rx_byte.perr || rx_byte.ferr);
    assign pop_tag   = rx_pop && !rx_empty && (rx_head.perr || rx_head.ferr);

    fifo_uart_baud u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .presc_sel (presc_sel),
        .baud_n    (baud_n),
        .tick16    (tick16)
    );

    fifo_uart_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .push  (tx_push),
        .pop   (tx_pop),
        .wdata (bus_wdata),
        .rdata (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    fifo_uart_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tick16     (tick16),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_head),
        .fifo_pop   (tx_pop),
        .txd        (txd)
    );

    fifo_uart_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick16    (tick16),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .rxd       (rxd),
        .byte_vld  (rx_byte_vld),
        .byte_out  (rx_byte),
        .brk_pulse (rx_brk),
        .rx_idle   (rx_idle)
    );

    fifo_uart_fifo #(.WIDTH(RXE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .push  (rx_push),
        .pop   (rx_pop),
        .wdata (rx_byte),
        .rdata (rx_head_raw),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // receive silence window
    assign tmo_arm = rx_idle && (rx_cnt != '0) && (rx_cnt < CNT_W'(RX_TRIG)) && !rx_pop;
    assign tmo_hit = tmo_arm && tick16 && (tmo_cnt == TMO_W'(TMO_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_sel  <= '0;
            par_en     <= 1'b0;
            par_odd    <= 1'b0;
            baud_n     <= '0;
            tmo_cnt    <= '0;
            err_cnt    <= '0;
            flag_tmo   <= 1'b0;
            flag_brk   <= 1'b0;
            flag_ovr   <= 1'b0;
            flag_txovf <= 1'b0;
        end else if (en) begin
            if (bus_wr && bus_addr == ADDR_CTRL) begin
                presc_sel <= bus_wdata[1:0];
                par_en    <= bus_wdata[2];
                par_odd   <= bus_wdata[3];
            end
            if (bus_wr && bus_addr == ADDR_BAUD) begin
                baud_n <= bus_wdata;
            end

            if (!tmo_arm || tmo_hit) begin
                tmo_cnt <= '0;
            end else if (tick16) begin
                tmo_cnt <= tmo_cnt + 1'b1;
            end

            case ({push_tag, pop_tag})
                2'b10:   err_cnt <= err_cnt + 1'b1;
                2'b01:   err_cnt <= err_cnt - 1'b1;
                default: err_cnt <= err_cnt;
            endcase

            flag_tmo   <= tmo_hit                  || (flag_tmo   && !(wr_status && bus_wdata[0]));
            flag_brk   <= rx_brk                   || (flag_brk   && !(wr_status && bus_wdata[1]));
            flag_ovr   <= (rx_push && rx_full)     || (flag_ovr   && !(wr_status && bus_wdata[2]));
            flag_txovf <= (wr_tx && tx_full)       || (flag_txovf && !(wr_status && bus_wdata[3]));
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_RXDATA: bus_rdata = rx_head.data;
            ADDR_CTRL:   bus_rdata = {4'b0, par_odd, par_en, presc_sel};
            ADDR_BAUD:   bus_rdata = baud_n;
            ADDR_STATUS: bus_rdata = {2'b0, rx_head.perr && !rx_empty, rx_head.ferr && !rx_empty,
                                      flag_txovf, flag_ovr, flag_brk, flag_tmo};
            ADDR_TXCNT:  bus_rdata = 8'(tx_cnt);
            ADDR_RXCNT:  bus_rdata = 8'(rx_cnt);
            ADDR_ERRCNT: bus_rdata = 8'(err_cnt);
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq_tx_empty = tx_empty;
    assign irq_break    = flag_brk;
    assign irq_rx_full  = (rx_cnt >= CNT_W'(RX_TRIG)) || flag_tmo;
    assign irq_rx_err   = (err_cnt != '0) || flag_ovr;
endmodule

// File: rtl/fifo_uart_port_checker.sv
module fifo_uart_port_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_stop,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic             txd,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] err_cnt,
    input logic             rx_byte_vld,
    input logic             rx_brk,
    input logic             rx_full,
    input logic             flag_ovr,
    input logic             flag_txovf
);
    assert_rx_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(DEPTH) && tx_cnt <= CNT_W'(DEPTH));

    assert_err_le_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= rx_cnt);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && tx_cnt == CNT_W'(DEPTH) && !clk_stop) |=> flag_txovf);

    assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_vld && rx_full && !clk_stop) |=> flag_ovr);

    assert_break_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_brk |-> !rx_byte_vld);

    assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop |=> ($stable(tx_cnt) && $stable(rx_cnt) && $stable(err_cnt) && $stable(txd)));
endmodule

bind fifo_uart_port fifo_uart_port_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_stop    (clk_stop),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .txd         (txd),
    .tx_cnt      (tx_cnt),
    .rx_cnt      (rx_cnt),
    .err_cnt     (err_cnt),
    .rx_byte_vld (rx_byte_vld),
    .rx_brk      (rx_brk),
    .rx_full     (rx_full),
    .flag_ovr    (flag_ovr),
    .flag_txovf  (flag_txovf)
);

// File: tb/test_fifo_uart_port.sv
`timescale 1ns/1ps
module test_fifo_uart_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_stop = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       txd, rxd_pin;
    logic       loop_en = 1'b0;
    logic       rx_drive = 1'b1;
    logic       irq_tx_empty, irq_break, irq_rx_full, irq_rx_err;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    assign rxd_pin = loop_en ? txd : rx_drive;

    fifo_uart_port i_fifo_uart_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_stop     (clk_stop),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .rxd          (rxd_pin),
        .txd          (txd),
        .irq_tx_empty (irq_tx_empty),
        .irq_break    (irq_break),
        .irq_rx_full  (irq_rx_full),
        .irq_rx_err   (irq_rx_err)
    );

    // {data[19:12], presc[11:10], par_en[9], par_odd[8], n[7:0]}
    localparam logic [19:0] VEC [6] = '{
        {8'hA5, 2'd0, 1'b0, 1'b0, 8'd0},
        {8'h01, 2'd0, 1'b1, 1'b0, 8'd0},
        {8'hFF, 2'd0, 1'b1, 1'b1, 8'd0},
        {8'h3B, 2'd1, 1'b0, 1'b0, 8'd1},
        {8'h81, 2'd2, 1'b1, 1'b1, 8'd0},
        {8'h57, 2'd0, 1'b1, 1'b0, 8'd2}
    };

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; loop_en = 1'b0; rx_drive = 1'b1; clk_stop = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic bus_pop(output logic [7:0] d);
        @(negedge clk);
        bus_addr = 3'd1; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] presc, input logic pen, input logic podd, input logic [7:0] n);
        bus_write(3'd2, {4'b0, podd, pen, presc});
        bus_write(3'd3, n);
    endtask

    task automatic drive_bit(input logic b, input int p);
        rx_drive = b;
        repeat (p) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                              input logic flip, input logic stopv, input int p);
        @(negedge clk);
        drive_bit(1'b0, p);
        for (int i = 0; i < 8; i++) drive_bit(d[i], p);
        if (pen) drive_bit((^d) ^ podd ^ flip, p);
        drive_bit(stopv, p);
        rx_drive = 1'b1;
        repeat (2 * p) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        do_reset();

        // R12 reset state
        check("R12", "txd idle", {15'b0, txd}, 16'd1);
        check("R12", "irq_tx_empty", {15'b0, irq_tx_empty}, 16'd1);
        check("R12", "other irqs", {13'b0, irq_break, irq_rx_full, irq_rx_err}, 16'd0);
        bus_read(3'd4, rd); check("R12", "status", {8'b0, rd}, 16'd0);
        bus_read(3'd6, rd); check("R12", "rx fill", {8'b0, rd}, 16'd0);

        // R1 R2 R3 loopback vectors
        for (int v = 0; v < 6; v++) begin
            logic [7:0] dat;
            int p, lowcnt, guard;
            dat = VEC[v][19:12];
            p = 16 * (VEC[v][7:0] + 1) * (VEC[v][11:10] == 2'd0 ? 1 : VEC[v][11:10] == 2'd1 ? 4 :
                                          VEC[v][11:10] == 2'd2 ? 16 : 64);
            loop_en = 1'b1;
            cfg(VEC[v][11:10], VEC[v][9], VEC[v][8], VEC[v][7:0]);
            bus_write(3'd0, dat);
            guard = 0;
            while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
            lowcnt = 0;
            while (txd === 1'b0 && lowcnt < 20000) begin lowcnt++; @(negedge clk); end
            check("R2", "start bit clocks", lowcnt[15:0], p[15:0]);
            repeat (12 * p) @(negedge clk);
            bus_read(3'd6, rd); check("R1", "rx fill after loopback", {8'b0, rd}, 16'd1);
            bus_read(3'd4, rd); check("R3", "no tags on clean frame", {14'b0, rd[5:4]}, 16'd0);
            bus_pop(rd); check("R1", "loopback byte", {8'b0, rd}, {8'b0, dat});
            check("R10", "tx empty after frame", {15'b0, irq_tx_empty}, 16'd1);
        end

        // R4 transmit fill while sending
        do_reset();
        cfg(2'd0, 1'b0, 1'b0, 8'd0);
        bus_write(3'd0, 8'h11); bus_write(3'd0, 8'h22); bus_write(3'd0, 8'h33);
        bus_read(3'd5, rd); check("R4", "tx fill", {8'b0, rd}, 16'd2);
        check("R10", "tx not empty", {15'b0, irq_tx_empty}, 16'd0);

        // R5 transmit overflow
        do_reset();
        cfg(2'd3, 1'b0, 1'b0, 8'd255);
        for (int i = 0; i < 20; i++) bus_write(3'd0, 8'(i));
        bus_read(3'd5, rd); check("R5", "tx fill capped", {8'b0, rd}, 16'd16);
        bus_read(3'd4, rd); check("R5", "overflow flag", {15'b0, rd[3]}, 16'd1);
        bus_write(3'd4, 8'h08);
        bus_read(3'd4, rd); check("R12", "w1c clears overflow", {15'b0, rd[3]}, 16'd0);

        // R3 parity error tag
        do_reset();
        cfg(2'd0, 1'b1, 1'b0, 8'd0);
        send_frame(8'h03, 1'b1, 1'b0, 1'b1, 1'b1, 16);
        bus_read(3'd7, rd); check("R4", "err count", {8'b0, rd}, 16'd1);
        bus_read(3'd4, rd); check("R3", "parity tag", {14'b0, rd[5:4]}, 16'd2);
        check("R10", "irq_rx_err set", {15'b0, irq_rx_err}, 16'd1);
        bus_pop(rd); check("R3", "byte kept", {8'b0, rd}, 16'h03);
        bus_read(3'd7, rd); check("R4", "err count after pop", {8'b0, rd}, 16'd0);
        check("R10", "irq_rx_err clear", {15'b0, irq_rx_err}, 16'd0);

        // R7 framing error tag
        do_reset();
        cfg(2'd0, 1'b0, 1'b0, 8'd0);
        send_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 16);
        bus_read(3'd4, rd); check("R7", "framing tag", {14'b0, rd[5:4]}, 16'd1);
        bus_pop(rd); check("R7", "byte kept", {8'b0, rd}, 16'h55);

        // R8 break
        do_reset();
        cfg(2'd0, 1'b0, 1'b0, 8'd0);
        @(negedge clk);
        drive_bit(1'b0, 14 * 16);
        bus_read(3'd4, rd); check("R8", "break flag", {15'b0, rd[1]}, 16'd1);
        check("R10", "irq_break", {15'b0, irq_break}, 16'd1);
        bus_read(3'd6, rd); check("R8", "no byte stored", {8'b0, rd}, 16'd0);
        bus_write(3'd4, 8'h02);
        drive_bit(1'b0, 14 * 16);
        bus_read(3'd4, rd); check("R8", "break once while low", {15'b0, rd[1]}, 16'd0);
        drive_bit(1'b1, 32);

        // R9 time-out
        do_reset();
        cfg(2'd0, 1'b0, 1'b0, 8'd0);
        send_frame(8'h42, 1'b0, 1'b0, 1'b0, 1'b1, 16);
        repeat (8 * 16) @(negedge clk);
        bus_read(3'd4, rd); check("R9", "no early time-out", {15'b0, rd[0]}, 16'd0);
        repeat (6 * 16) @(negedge clk);
        bus_read(3'd4, rd); check("R9", "time-out set", {15'b0, rd[0]}, 16'd1);
        check("R10", "irq_rx_full by time-out", {15'b0, irq_rx_full}, 16'd1);

        // R6 overrun and R10 threshold
        do_reset();
        cfg(2'd0, 1'b0, 1'b0, 8'd0);
        for (int i = 0; i < 17; i++) begin
            send_frame(8'h10 + 8'(i), 1'b0, 1'b0, 1'b0, 1'b1, 16);
            if (i == 6) check("R10", "below threshold", {15'b0, irq_rx_full}, 16'd0);
            if (i == 7) check("R10", "at threshold", {15'b0, irq_rx_full}, 16'd1);
        end
        bus_read(3'd6, rd); check("R6", "rx fill capped", {8'b0, rd}, 16'd16);
        bus_read(3'd4, rd); check("R6", "overrun flag", {15'b0, rd[2]}, 16'd1);
        check("R10", "irq_rx_err by overrun", {15'b0, irq_rx_err}, 16'd1);
        bus_pop(rd); check("R6", "oldest kept", {8'b0, rd}, 16'h10);

        // R11 clock stop
        do_reset();
        cfg(2'd0, 1'b0, 1'b0, 8'd0);
        @(negedge clk); clk_stop = 1'b1;
        bus_write(3'd0, 8'h12);
        bus_read(3'd5, rd); check("R11", "tx write ignored", {8'b0, rd}, 16'd0);
        check("R11", "txd held", {15'b0, txd}, 16'd1);
        send_frame(8'h66, 1'b0, 1'b0, 1'b0, 1'b1, 16);
        bus_read(3'd6, rd); check("R11", "rx frozen", {8'b0, rd}, 16'd0);
        clk_stop = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule